// File: doc/BRIEF.md
# Four-Channel Fan PWM Generator

This block drives four cooling-fan PWM pins from a small bank of word-addressed registers. The channels are grouped in pairs. Each pair has an 8-bit prescaler that divides the system clock by its programmed value plus one. Each channel has a down-counting period counter that steps once per prescaled tick of its pair. When the counter reaches zero it reloads from the channel's period register. The pin is active while the counter is at or below the channel's active duty threshold.

Software writes the duty threshold whenever it likes. The channel copies the new value only when the counter reloads, so a period in progress always finishes with the threshold it began with. A fan is switched fully off by clearing its enable bit and setting its invert bit, which parks the pin at the inverted idle level. A per-channel continuous bit selects between auto-reload and a single pass that halts at zero.

The register port has no data stream, so it is a plain one-cycle write strobe with a combinational read path. Reads have no side effects, and nothing in the port applies back-pressure.

Top module: `fanpwm_quad`

## Requirements
- R1: After reset, every PWM pin is low. The control word reads 0x00088808 (only the continuous bits set). Every period register and every duty register reads 255. Both prescale fields read 0.
- R2: Registers sit at byte offsets that are multiples of 4. Prescale is at 0x00 and control is at 0x08. Channel c has its period at 0x0C+12c, its duty at 0x10+12c and a read-only live count at 0x14+12c. Each value sits in the low bits of its word.
- R3: Prescale bits [7:0] set the divider for channels 0 and 1, and bits [15:8] set it for channels 2 and 3. A field value of N≥1 gives one counter step every N+1 clocks.
- R4: A prescale field of 0 stops the counters of both channels in that pair.
- R5: An enabled continuous channel counts down by one per tick. At zero it reloads from its period register, so one output period lasts (period+1) ticks.
- R6: An enabled non-inverted pin is high exactly while the count is at or below the active duty value. A duty of 255 therefore gives a pin that is high all the time.
- R7: The invert bit inverts the enabled waveform. A disabled pin rests at the value of its invert bit.
- R8: The enable bits are at control positions 0, 8, 12 and 16 for channels 0–3. The invert bits sit 2 above each enable bit and the continuous bits sit 3 above. All other control bits read 0.
- R9: A duty write takes effect only when the counter reloads at zero. Until then the period in progress keeps the old duty value.
- R10: With its continuous bit clear, an enabled channel counts down to zero once and then holds zero.
- R11: While a channel is disabled, its count is held at its period register value.
- R12: Writes to unmapped offsets and to live-count registers have no effect. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | 4 | PWM pins, bit c drives channel c |

## Verification
The hardest case to reach is a duty write that lands in the middle of a period. It must not touch the waveform until the counter next reloads. To land there, the bench slows the pair's prescaler to divide by four and polls the channel's live-count register until it shows a mid-period value. It then writes the new duty and checks that the pin stays at the old level for the rest of the period. The stopped-prescaler and single-pass cases are similar. Neither shows on the pin, so both are checked by reading the live count twice, many cycles apart.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;

  localparam int REG_W = 32;
  localparam int CH_STRIDE = 12;
  localparam logic [7:0] OFS_PRESCALE = 8'h00;
  localparam logic [7:0] OFS_CTRL     = 8'h08;
  localparam logic [7:0] OFS_CH_BASE  = 8'h0C;

  // control layout: channel 0 at bit 0, channel c>0 at 4c+4
  function automatic int en_pos(input int ch);
    return (ch == 0) ? 0 : (4 * ch + 4);
  endfunction

  function automatic int inv_pos(input int ch);
    return en_pos(ch) + 2;
  endfunction

  function automatic int cont_pos(input int ch);
    return en_pos(ch) + 3;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_mask(input int nch);
    logic [REG_W-1:0] m;
    m = '0;
    for (int c = 0; c < nch; c++) begin
      m[en_pos(c)]   = 1'b1;
      m[inv_pos(c)]  = 1'b1;
      m[cont_pos(c)] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_reset(input int nch);
    logic [REG_W-1:0] m;
    m = '0;
    for (int c = 0; c < nch; c++) m[cont_pos(c)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/fanpwm_regs.sv
module fanpwm_regs
  import fanpwm_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_PAIRS = 2,
  parameter int CNT_W     = 8,
  parameter int PRE_W     = 8,
  parameter int ADDR_W    = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [REG_W-1:0]                     wdata,
  output logic [REG_W-1:0]                     rdata,
  output logic [NUM_PAIRS-1:0][PRE_W-1:0]      pre_div,
  output logic [REG_W-1:0]                     ctrl,
  output logic [NUM_CH-1:0][CNT_W-1:0]         period,
  output logic [NUM_CH-1:0][CNT_W-1:0]         duty,
  input  logic [NUM_CH-1:0][CNT_W-1:0]         live_cnt
);

  localparam int PRE_BITS = NUM_PAIRS * PRE_W;
  localparam logic [REG_W-1:0] CTRL_MASK = ctrl_mask(NUM_CH);
  localparam logic [REG_W-1:0] CTRL_RST  = ctrl_reset(NUM_CH);

  function automatic logic [ADDR_W-1:0] ch_ofs(input int c, input int k);
    return ADDR_W'(int'(OFS_CH_BASE) + CH_STRIDE * c + 4 * k);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_div <= '0;
      ctrl    <= CTRL_RST;
      period  <= '1;
      duty    <= '1;
    end else if (wr) begin
      if (addr == ADDR_W'(OFS_PRESCALE)) pre_div <= wdata[PRE_BITS-1:0];
      if (addr == ADDR_W'(OFS_CTRL))     ctrl    <= wdata & CTRL_MASK;
      for (int c = 0; c < NUM_CH; c++) begin
        if (addr == ch_ofs(c, 0)) period[c] <= wdata[CNT_W-1:0];
        if (addr == ch_ofs(c, 1)) duty[c]   <= wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_PRESCALE)) rdata[PRE_BITS-1:0] = pre_div;
    if (addr == ADDR_W'(OFS_CTRL))     rdata = ctrl;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ch_ofs(c, 0)) rdata[CNT_W-1:0] = period[c];
      if (addr == ch_ofs(c, 1)) rdata[CNT_W-1:0] = duty[c];
      if (addr == ch_ofs(c, 2)) rdata[CNT_W-1:0] = live_cnt[c];
    end
  end

endmodule

// File: rtl/fanpwm_prescaler.sv
module fanpwm_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);

  logic [PRE_W-1:0] phase;

  // field value 0 parks the divider: no ticks at all
  assign tick = (div != '0) && (phase >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         phase <= '0;
    else if (div == '0 || phase >= div) phase <= '0;
    else                                phase <= phase + 1'b1;
  end

endmodule

// File: rtl/fanpwm_channel.sv
module fanpwm_channel #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             inv,
  input  logic             cont,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] duty_act,
  output logic             pwm
);

  logic at_zero;
  assign at_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '1;
      duty_act <= '1;
    end else if (!en) begin
      cnt      <= period;
      duty_act <= duty;
    end else if (tick) begin
      if (!at_zero) begin
        cnt <= cnt - 1'b1;
      end else if (cont) begin
        cnt      <= period;
        duty_act <= duty;
      end
    end
  end

  assign pwm = en ? ((cnt <= duty_act) ^ inv) : inv;

endmodule

// File: rtl/fanpwm_quad.sv
module fanpwm_quad
  import fanpwm_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int CH_PER_PAIR = 2,
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 8,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  localparam int NUM_PAIRS = (NUM_CH + CH_PER_PAIR - 1) / CH_PER_PAIR;

  logic [NUM_PAIRS-1:0][PRE_W-1:0] pre_div;
  logic [NUM_PAIRS-1:0]            pair_tick;
  logic [REG_W-1:0]                ctrl;
  logic [NUM_CH-1:0][CNT_W-1:0]    period, duty, live_cnt, duty_act;
  logic [NUM_CH-1:0]               en_vec, inv_vec, cont_vec, ch_tick;

  fanpwm_regs #(
    .NUM_CH(NUM_CH), .NUM_PAIRS(NUM_PAIRS), .CNT_W(CNT_W),
    .PRE_W(PRE_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .pre_div(pre_div),
    .ctrl(ctrl), .period(period), .duty(duty), .live_cnt(live_cnt)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    fanpwm_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .div(pre_div[p]), .tick(pair_tick[p])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int PAIR = c / CH_PER_PAIR;
    assign en_vec[c]   = ctrl[en_pos(c)];
    assign inv_vec[c]  = ctrl[inv_pos(c)];
    assign cont_vec[c] = ctrl[cont_pos(c)];
    assign ch_tick[c]  = pair_tick[PAIR];

    fanpwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(ch_tick[c]), .en(en_vec[c]),
      .inv(inv_vec[c]), .cont(cont_vec[c]), .period(period[c]),
      .duty(duty[c]), .cnt(live_cnt[c]), .duty_act(duty_act[c]),
      .pwm(pwm_out[c])
    );
  end

endmodule

// File: rtl/fanpwm_quad_chk.sv
module fanpwm_quad_chk #(
  parameter int NUM_CH      = 4,
  parameter int NUM_PAIRS   = 2,
  parameter int CH_PER_PAIR = 2,
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NUM_CH-1:0]               pwm_out,
  input logic [NUM_CH-1:0]               en_vec,
  input logic [NUM_CH-1:0]               cont_vec,
  input logic [NUM_CH-1:0]               ch_tick,
  input logic [NUM_PAIRS-1:0][PRE_W-1:0] pre_div,
  input logic [NUM_CH-1:0][CNT_W-1:0]    period,
  input logic [NUM_CH-1:0][CNT_W-1:0]    duty,
  input logic [NUM_CH-1:0][CNT_W-1:0]    live_cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0]    duty_act
);

  // R1: pins idle low on the first cycle out of reset
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pwm_out == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    localparam int P = c / CH_PER_PAIR;

    a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_vec[c]) && $past(ch_tick[c]) && $past(live_cnt[c]) != '0)
      |-> (live_cnt[c] == $past(live_cnt[c]) - 1'b1));

    a_r5_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_vec[c]) && $past(ch_tick[c]) && $past(live_cnt[c]) == '0 && $past(cont_vec[c]))
      |-> (live_cnt[c] == $past(period[c]) && duty_act[c] == $past(duty[c])));

    a_r4_stopped_prescaler: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_vec[c]) && $past(pre_div[P]) == '0)
      |-> (live_cnt[c] == $past(live_cnt[c])));

    a_r9_duty_held_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_vec[c]) && !($past(ch_tick[c]) && $past(live_cnt[c]) == '0))
      |-> (duty_act[c] == $past(duty_act[c])));

    a_r10_single_pass_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_vec[c]) && $past(live_cnt[c]) == '0 && !$past(cont_vec[c]))
      |-> (live_cnt[c] == '0));

    a_r11_disabled_tracks_period: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_vec[c]) |-> (live_cnt[c] == $past(period[c])));
  end

endmodule

bind fanpwm_quad fanpwm_quad_chk #(
  .NUM_CH(NUM_CH), .NUM_PAIRS(NUM_PAIRS), .CH_PER_PAIR(CH_PER_PAIR),
  .CNT_W(CNT_W), .PRE_W(PRE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .en_vec(en_vec),
  .cont_vec(cont_vec), .ch_tick(ch_tick), .pre_div(pre_div),
  .period(period), .duty(duty), .live_cnt(live_cnt), .duty_act(duty_act)
);

// File: tb/fanpwm_quad_tb.sv
module fanpwm_quad_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  fanpwm_quad u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  // control word from R8 layout; continuous bits set unless cleared
  function automatic logic [31:0] ctl(input logic [3:0] en, input logic [3:0] inv,
                                      input logic [3:0] cont);
    int p;
    logic [31:0] w;
    w = '0;
    for (int c = 0; c < 4; c++) begin
      p = (c == 0) ? 0 : 4 * c + 4;
      w[p] = en[c]; w[p+2] = inv[c]; w[p+3] = cont[c];
    end
    return w;
  endfunction

  function automatic logic [7:0] ofs(input int c, input int k);
    return 8'(12 + 12 * c + 4 * k);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic measure(input int ch, input int n, output int highs, output int rises);
    logic prev;
    highs = 0; rises = 0;
    @(negedge clk); prev = pwm_out[ch];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) highs++;
      if (pwm_out[ch] && !prev) rises++;
      prev = pwm_out[ch];
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk);
    check(pwm_out == 4'b0000, "R1 pins low", pwm_out, 0);
    rd(8'h08, d); check(d == 32'h00088808, "R1 control reset", d, 32'h00088808);
    rd(ofs(0, 0), d); check(d == 255, "R1 R2 period reset", d, 255);
    rd(ofs(3, 1), d); check(d == 255, "R1 R2 duty reset", d, 255);
    rd(8'h00, d); check(d == 0, "R1 prescale reset", d, 0);
  endtask

  task automatic t_duty;
    int h, r;
    wr(8'h00, 32'h0101);
    wr(ofs(0, 0), 7); wr(ofs(0, 1), 2);
    wr(8'h08, ctl(4'b0001, 4'b0000, 4'b1111));
    repeat (64) @(posedge clk);
    measure(0, 64, h, r);
    check(h == 24, "R6 duty 3/8 high", h, 24);
    check(r == 4, "R3 R5 period 16 clocks", r, 4);
  endtask

  task automatic t_invert;
    int h, r;
    wr(8'h08, ctl(4'b0001, 4'b0001, 4'b1111));
    repeat (40) @(posedge clk);
    measure(0, 64, h, r);
    check(h == 40, "R7 inverted duty", h, 40);
  endtask

  task automatic t_full;
    int h, r;
    wr(8'h08, ctl(4'b0001, 4'b0000, 4'b1111));
    wr(ofs(0, 1), 255);
    repeat (40) @(posedge clk);
    measure(0, 64, h, r);
    check(h == 64, "R6 full duty", h, 64);
  endtask

  task automatic t_idle;
    int h, r;
    wr(8'h08, ctl(4'b0000, 4'b0001, 4'b1111));
    measure(0, 32, h, r);
    check(h == 32, "R7 disabled inverted idle high", h, 32);
    wr(8'h08, ctl(4'b0000, 4'b0000, 4'b1111));
    measure(0, 32, h, r);
    check(h == 0, "R7 disabled plain idle low", h, 0);
  endtask

  task automatic t_pairs;
    int h, r;
    wr(8'h00, 32'h0301);
    wr(ofs(1, 0), 7); wr(ofs(1, 1), 3);
    wr(ofs(2, 0), 7); wr(ofs(2, 1), 3);
    wr(8'h08, ctl(4'b0110, 4'b0000, 4'b1111));
    repeat (80) @(posedge clk);
    measure(1, 128, h, r);
    check(r == 8, "R3 R8 ch1 low field divide 2", r, 8);
    check(h == 64, "R6 ch1 half duty", h, 64);
    measure(2, 128, h, r);
    check(r == 4, "R3 R8 ch2 high field divide 4", r, 4);
    check(h == 64, "R6 ch2 half duty", h, 64);
  endtask

  task automatic t_stop;
    logic [31:0] a, b;
    wr(8'h08, ctl(4'b0000, 4'b0000, 4'b1111));
    wr(8'h00, 32'h0300);
    wr(8'h08, ctl(4'b0001, 4'b0000, 4'b1111));
    rd(ofs(0, 2), a);
    repeat (30) @(posedge clk);
    rd(ofs(0, 2), b);
    check(a == 7, "R4 R11 count parked at period", a, 7);
    check(b == 7, "R4 count stays when field is 0", b, 7);
  endtask

  task automatic t_boundary;
    logic [31:0] d;
    int h, r, guard;
    bit low_ok;
    wr(8'h08, ctl(4'b0000, 4'b0000, 4'b1111));
    wr(8'h00, 32'h0003);
    wr(ofs(1, 0), 7); wr(ofs(1, 1), 0);
    wr(8'h08, ctl(4'b0010, 4'b0000, 4'b1111));
    guard = 0;
    do begin rd(ofs(1, 2), d); guard++; end while (d != 5 && guard < 200);
    check(d == 5, "R9 reached mid period", d, 5);
    wr(ofs(1, 1), 7);
    low_ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (pwm_out[1]) low_ok = 1'b0;
    end
    check(low_ok, "R9 old duty kept mid period", pwm_out[1], 0);
    repeat (40) @(posedge clk);
    measure(1, 32, h, r);
    check(h == 32, "R9 new duty after reload", h, 32);
  endtask

  task automatic t_single;
    logic [31:0] a, b;
    wr(8'h08, ctl(4'b0000, 4'b0000, 4'b1111));
    wr(8'h00, 32'h0100);
    wr(ofs(3, 0), 7); wr(ofs(3, 1), 2);
    wr(8'h08, ctl(4'b1000, 4'b0000, 4'b0111));
    repeat (60) @(posedge clk);
    rd(ofs(3, 2), a);
    repeat (30) @(posedge clk);
    rd(ofs(3, 2), b);
    check(a == 0, "R10 single pass reached zero", a, 0);
    check(b == 0, "R10 single pass holds zero", b, 0);
    check(pwm_out[3] == 1'b1, "R10 R6 pin active at zero", pwm_out[3], 1);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(8'h08, ctl(4'b0000, 4'b0000, 4'b1111));
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); check(d == 0, "R12 unmapped reads 0", d, 0);
    wr(8'h3C, 32'h1234_5678);
    rd(8'h3C, d); check(d == 0, "R12 past last channel reads 0", d, 0);
    wr(ofs(0, 2), 32'hAA);
    rd(ofs(0, 2), d); check(d == 7, "R12 live count not writable", d, 7);
    rd(ofs(0, 0), d); check(d == 7, "R12 period untouched", d, 7);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); check(d == 32'h000DDD0D, "R8 only defined control bits", d, 32'h000DDD0D);
    wr(8'h08, ctl(4'b0000, 4'b0000, 4'b1111));
  endtask

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_duty();
        t_invert();
        t_full();
        t_idle();
        t_pairs();
        t_stop();
        t_boundary();
        t_single();
        t_unmapped();
      end
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule